// File: doc/BRIEF.md
# Cache way-lock replacement selector

This block decides which way of a 4-way set-associative operand cache receives a new line when an access misses. A cache controller presents, for the addressed set, the hit vector, a flag that marks the access as a prefetch, a miss strobe and the way its ordinary replacement policy would pick, together with a per-way age value (larger means older). One cycle later the block answers with a fill enable and a one-hot victim way.

A 32-bit control register sets the locking behaviour. It has a global lock-enable bit and, for ways 3 and 2, a lock bit and a load bit. When locking is off, the block passes the base choice through unchanged. When locking is on, ordinary misses are kept out of locked ways, and a prefetch miss may be sent into a way that is both locked and selected for loading. Software is expected never to set both load bits. If it does, way 3 wins and a sticky error flag becomes visible in the register.

Top module: `way_lock_victim_sel`

## Requirements
- R1: After reset the register reads 0x00000000 and both fill enable and victim are 0.
- R2: Register bit 16 is lock-enable, bit 9 is way-3 load, bit 8 is way-3 lock, bit 1 is way-2 load and bit 0 is way-2 lock. They are written by a write strobe and read back on the next cycle. Bit 31 is a read-only error flag. Every other bit reads 0 and ignores writes.
- R3: With lock-enable at 0, a miss fills the base way (one-hot) whatever the lock and load bits are, for prefetch and ordinary accesses alike.
- R4: An access with any hit bit set gives fill enable 0 and victim 0 on the next cycle. This includes prefetch hits, whatever the load bits are.
- R5: With lock-enable 1, a prefetch miss with way-3 load and way-3 lock both at 1 fills way 3 (4'b1000).
- R6: With lock-enable 1, a prefetch miss with way-3 load and way-3 lock not both at 1, and with way-2 load and way-2 lock both at 1, fills way 2 (4'b0100).
- R7: With lock-enable 1, an ordinary miss whose base way is locked fills the oldest unlocked way. Ties go to the lowest way index.
- R8: With lock-enable 1, an ordinary miss whose base way is unlocked fills the base way.
- R9: A write that sets both load bits sets the error flag (bit 31) on the next cycle. The flag stays set until reset. With both load-and-lock pairs active, a prefetch miss fills way 3.
- R10: Fill enable and victim are registered: they answer the miss strobe of the previous cycle, and both are 0 in any cycle whose previous cycle had no miss strobe.
- R11: With lock-enable 1, a prefetch miss that matches neither load-and-lock pair follows the ordinary-miss rules of R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 32 | Control register write data |
| reg_rdata_o | output | 32 | Control register read data |
| miss_i | input | 1 | Access strobe for the addressed set |
| pref_i | input | 1 | Access is a prefetch |
| hit_way_i | input | 4 | Per-way hit vector |
| base_way_i | input | 4 | One-hot base replacement choice |
| way_age_i | input | 4*AGE_W | Per-way age, way 0 in the low bits, larger means older |
| fill_en_o | output | 1 | A line fill is required |
| victim_o | output | 4 | One-hot way to fill |

## Verification
A register write shows up on the read port one cycle after the strobe edge. The victim and fill enable for a miss are due exactly one cycle after the strobe. Every operation in the bench drives its inputs on a falling edge and samples just after the next rising edge, so each check sees the first cycle in which the result is valid. For R10, the cycle that follows a strobe with no new strobe is also checked, to confirm that the outputs return to zero.

// File: rtl/wls_pkg.sv
`timescale 1ns/1ps
package wls_pkg;
    localparam int NWAYS   = 4;
    localparam int DATA_W  = 32;
    localparam int B_LE    = 16;
    localparam int B_W3LD  = 9;
    localparam int B_W3LK  = 8;
    localparam int B_W2LD  = 1;
    localparam int B_W2LK  = 0;
    localparam int B_ERR   = 31;

    typedef struct packed {
        logic le;
        logic w3ld;
        logic w3lk;
        logic w2ld;
        logic w2lk;
        logic err;
    } ctl_t;

    typedef struct packed {
        logic             fill;
        logic [NWAYS-1:0] vic;
    } out_t;
endpackage

// File: rtl/wls_ctrl_reg.sv
`timescale 1ns/1ps
module wls_ctrl_reg
    import wls_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output ctl_t              ctl_o,
    output logic [DATA_W-1:0] rdata_o
);
    ctl_t ctl_d, ctl_q;
    logic unused_wbits;

    assign unused_wbits = &wdata_i;

    always_comb begin
        ctl_d = ctl_q;
        if (we_i) begin
            ctl_d.le   = wdata_i[B_LE];
            ctl_d.w3ld = wdata_i[B_W3LD];
            ctl_d.w3lk = wdata_i[B_W3LK];
            ctl_d.w2ld = wdata_i[B_W2LD];
            ctl_d.w2lk = wdata_i[B_W2LK];
            // both load bits at once is a software error: latch it
            if (wdata_i[B_W3LD] && wdata_i[B_W2LD]) ctl_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    always_comb begin
        rdata_o         = '0;
        rdata_o[B_LE]   = ctl_q.le;
        rdata_o[B_W3LD] = ctl_q.w3ld;
        rdata_o[B_W3LK] = ctl_q.w3lk;
        rdata_o[B_W2LD] = ctl_q.w2ld;
        rdata_o[B_W2LK] = ctl_q.w2lk;
        rdata_o[B_ERR]  = ctl_q.err;
    end

    assign ctl_o = ctl_q;
endmodule

// File: rtl/wls_victim_pick.sv
`timescale 1ns/1ps
module wls_victim_pick
    import wls_pkg::*;
#(
    parameter int AGE_W = 2
) (
    input  ctl_t                   ctl_i,
    input  logic                   pref_i,
    input  logic [NWAYS-1:0]       base_i,
    input  logic [NWAYS*AGE_W-1:0] age_i,
    output logic [NWAYS-1:0]       victim_o
);
    logic [NWAYS-1:0] locked;
    logic [NWAYS-1:0] oldest;
    logic [NWAYS-1:0] restricted;
    logic [AGE_W-1:0] best_age;
    logic             found;

    always_comb begin
        locked    = '0;
        locked[3] = ctl_i.le & ctl_i.w3lk;
        locked[2] = ctl_i.le & ctl_i.w2lk;
    end

    // oldest unlocked way; strict compare keeps the lowest index on ties
    always_comb begin
        oldest   = '0;
        best_age = '0;
        found    = 1'b0;
        for (int w = 0; w < NWAYS; w++) begin
            if (!locked[w] && (!found || age_i[w*AGE_W +: AGE_W] > best_age)) begin
                found    = 1'b1;
                best_age = age_i[w*AGE_W +: AGE_W];
                oldest   = '0;
                oldest[w] = 1'b1;
            end
        end
    end

    assign restricted = ((base_i & locked) != '0) ? oldest : base_i;

    always_comb begin
        if (!ctl_i.le)                               victim_o = base_i;
        else if (pref_i && ctl_i.w3ld && ctl_i.w3lk) victim_o = 4'b1000;
        else if (pref_i && ctl_i.w2ld && ctl_i.w2lk) victim_o = 4'b0100;
        else                                         victim_o = restricted;
    end
endmodule

// File: rtl/way_lock_victim_sel.sv
`timescale 1ns/1ps
module way_lock_victim_sel
    import wls_pkg::*;
#(
    parameter int AGE_W = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   reg_we_i,
    input  logic [31:0]            reg_wdata_i,
    output logic [31:0]            reg_rdata_o,
    input  logic                   miss_i,
    input  logic                   pref_i,
    input  logic [3:0]             hit_way_i,
    input  logic [3:0]             base_way_i,
    input  logic [4*AGE_W-1:0]     way_age_i,
    output logic                   fill_en_o,
    output logic [3:0]             victim_o
);
    ctl_t             ctl;
    logic [NWAYS-1:0] pick;
    out_t             out_d, out_q;

    wls_ctrl_reg u_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (reg_we_i),
        .wdata_i (reg_wdata_i),
        .ctl_o   (ctl),
        .rdata_o (reg_rdata_o)
    );

    wls_victim_pick #(.AGE_W(AGE_W)) u_pick (
        .ctl_i    (ctl),
        .pref_i   (pref_i),
        .base_i   (base_way_i),
        .age_i    (way_age_i),
        .victim_o (pick)
    );

    always_comb begin
        out_d      = '0;
        out_d.fill = miss_i && (hit_way_i == '0);
        if (out_d.fill) out_d.vic = pick;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign fill_en_o = out_q.fill;
    assign victim_o  = out_q.vic;
endmodule

// File: rtl/way_lock_victim_sel_chk.sv
`timescale 1ns/1ps
module way_lock_victim_sel_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [31:0] reg_rdata_o,
    input logic        miss_i,
    input logic        pref_i,
    input logic [3:0]  hit_way_i,
    input logic [3:0]  base_way_i,
    input logic        fill_en_o,
    input logic [3:0]  victim_o
);
    p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rdata_o & ~32'h8001_0303) == 32'h0);

    p_base_when_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (miss_i && hit_way_i == 4'b0 && !reg_rdata_o[16]) |=> victim_o == $past(base_way_i));

    p_no_fill_on_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (miss_i && hit_way_i != 4'b0) |=> (!fill_en_o && victim_o == 4'b0));

    p_locked_avoided_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (miss_i && !pref_i && hit_way_i == 4'b0 && reg_rdata_o[16])
        |=> (victim_o & {$past(reg_rdata_o[8]), $past(reg_rdata_o[0]), 2'b00}) == 4'b0);

    p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_o[31] |=> reg_rdata_o[31]);

    p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !miss_i |=> (!fill_en_o && victim_o == 4'b0));

    p_victim_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill_en_o |-> $countones(victim_o) == 1);
endmodule

bind way_lock_victim_sel way_lock_victim_sel_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_rdata_o (reg_rdata_o),
    .miss_i      (miss_i),
    .pref_i      (pref_i),
    .hit_way_i   (hit_way_i),
    .base_way_i  (base_way_i),
    .fill_en_o   (fill_en_o),
    .victim_o    (victim_o)
);

// File: tb/way_lock_victim_sel_bench.sv
`timescale 1ns/1ps
module way_lock_victim_sel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        miss = 1'b0;
    logic        pref = 1'b0;
    logic [3:0]  hit = '0;
    logic [3:0]  base = 4'b0001;
    logic [7:0]  age = '0;
    logic        fill;
    logic [3:0]  vic;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    way_lock_victim_sel u_way_lock_victim_sel (
        .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .miss_i(miss), .pref_i(pref), .hit_way_i(hit),
        .base_way_i(base), .way_age_i(age), .fill_en_o(fill), .victim_o(vic)
    );

    typedef struct packed {
        logic [31:0] ctl;
        logic        pf;
        logic [3:0]  ht;
        logic [3:0]  bs;
        logic [7:0]  ag;
        logic        xfill;
        logic [3:0]  xvic;
    } vec_t;

    // ages packed way3..way0, two bits each
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_0303, 1'b0, 4'b0000, 4'b1000, 8'h00, 1'b1, 4'b1000}, // R3
        '{32'h0000_0303, 1'b1, 4'b0000, 4'b0100, 8'h00, 1'b1, 4'b0100}, // R3
        '{32'h0001_0101, 1'b1, 4'b0001, 4'b0100, 8'h00, 1'b0, 4'b0000}, // R4
        '{32'h0001_0101, 1'b0, 4'b0100, 4'b0001, 8'h00, 1'b0, 4'b0000}, // R4
        '{32'h0001_0300, 1'b1, 4'b0000, 4'b0001, 8'h00, 1'b1, 4'b1000}, // R5
        '{32'h0001_0300, 1'b0, 4'b0000, 4'b1000, 8'h2D, 1'b1, 4'b0010}, // R7
        '{32'h0001_0003, 1'b1, 4'b0000, 4'b0001, 8'h00, 1'b1, 4'b0100}, // R6
        '{32'h0001_0101, 1'b0, 4'b0000, 4'b0100, 8'h00, 1'b1, 4'b0001}, // R7 tie
        '{32'h0001_0101, 1'b0, 4'b0000, 4'b1000, 8'hF9, 1'b1, 4'b0010}, // R7
        '{32'h0001_0101, 1'b0, 4'b0000, 4'b0010, 8'hFF, 1'b1, 4'b0010}, // R8
        '{32'h0001_0201, 1'b1, 4'b0000, 4'b0100, 8'h80, 1'b1, 4'b1000}, // R11
        '{32'h0001_0100, 1'b1, 4'b0000, 4'b0010, 8'h00, 1'b1, 4'b0010}  // R11
    };
    localparam string TAGS [NV] = '{"R3", "R3", "R4", "R4", "R5", "R7",
                                    "R6", "R7", "R7", "R8", "R11", "R11"};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic access(input logic pf, input logic [3:0] ht, input logic [3:0] bs,
                          input logic [7:0] ag);
        @(negedge clk);
        miss = 1'b1; pref = pf; hit = ht; base = bs; age = ag;
        @(posedge clk);
        #1;
        miss = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", rdata, 32'h0);
        chk("R1", {31'b0, fill}, 32'h0);
        chk("R1", {28'b0, vic}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: only defined bits stick, bit 31 not writable
        wr(32'hFFFF_FDFD);
        chk("R2", rdata, 32'h0001_0101);
        wr(32'h7FFE_FCFC);
        chk("R2", rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].ctl);
            access(VEC[i].pf, VEC[i].ht, VEC[i].bs, VEC[i].ag);
            chk(TAGS[i], {31'b0, fill}, {31'b0, VEC[i].xfill});
            chk(TAGS[i], {28'b0, vic}, {28'b0, VEC[i].xvic});
        end

        // R10: outputs drop the cycle after a lone strobe
        wr(32'h0);
        access(1'b0, 4'b0000, 4'b0010, 8'h00);
        chk("R10", {27'b0, fill, vic}, {27'b0, 1'b1, 4'b0010});
        @(posedge clk);
        #1;
        chk("R10", {27'b0, fill, vic}, 32'h0);

        // R9: both load bits -> error flag, way 3 priority, sticky
        wr(32'h0001_0303);
        chk("R9", rdata, 32'h8001_0303);
        access(1'b1, 4'b0000, 4'b0001, 8'h00);
        chk("R9", {28'b0, vic}, 32'h8);
        wr(32'h0001_0000);
        chk("R9", rdata, 32'h8001_0000);
        wr(32'h0);
        chk("R9", rdata, 32'h8000_0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule